// File: doc/BRIEF.md
# Privilege-Gated Interrupt Selector

This block decides which local interrupt a hart should take. It combines the pending register with the enable mask and with the delegation mask. It then qualifies each candidate by the hart's current privilege level and the two global enable bits. The lowest-numbered bit that survives is reported as the cause. The decision is fully combinational, so the take flag and the cause follow their inputs in the same cycle.

The block also owns the pending register. A masked update port writes it: bits selected by the mask take the supplied value and all other bits keep their state. The register value that is about to be replaced is always visible on an output.

A claim register lets interrupt sources reserve pending bits for themselves. A reservation succeeds only when none of the requested bits is already held. Reserved bits stay held until reset.

Top module: `irq_selector`

## Requirements
- R1: While reset is high, the pending register and the claim register are cleared at the clock edge. After reset, pendingOld and claimOut read zero and takeIrq is low.
- R2: Only bits set in both the pending register and enableMask are candidates. A pending bit whose enable is 0 is never taken.
- R3: A candidate whose delegMask bit is 0 is eligible when privLvl is U (0) or S (1), or when privLvl is M (3) and mIntEn is 1.
- R4: A candidate whose delegMask bit is 1 is eligible when privLvl is U (0), or when privLvl is S (1) and sIntEn is 1. It is never eligible in M (3).
- R5: When at least one bit is eligible, takeIrq is 1 and irqCause is the index of the lowest-numbered eligible bit.
- R6: When no bit is eligible, takeIrq is 0 and irqCause is 0.
- R7: When updValid is 1 at a clock edge, the pending register becomes (old & ~updMask) | (updValue & updMask). During that cycle, pendingOld shows the value before the update.
- R8: When updValid is 0, the pending register keeps its value, whatever updMask and updValue carry.
- R9: A claim request whose claimBits overlap the claim register raises claimReject in the same cycle and leaves the claim register unchanged.
- R10: A claim request with no overlap raises claimGrant in the same cycle. At the next edge, claimBits are ORed into the claim register.
- R11: takeIrq and irqCause are combinational. They settle in the same cycle that privLvl, the enable bits or the masks change, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| privLvl | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| mIntEn | input | 1 | Machine-level global interrupt enable |
| sIntEn | input | 1 | Supervisor-level global interrupt enable |
| enableMask | input | NUM_IRQ | Per-interrupt enable bits |
| delegMask | input | NUM_IRQ | Per-interrupt delegation-to-S bits |
| updValid | input | 1 | Apply a masked write to the pending register |
| updMask | input | NUM_IRQ | Bits of the pending register to overwrite |
| updValue | input | NUM_IRQ | New values for the masked bits |
| pendingOld | output | NUM_IRQ | Current pending value (the value replaced by an update) |
| claimValid | input | 1 | Claim request strobe |
| claimBits | input | NUM_IRQ | Bits to reserve |
| claimGrant | output | 1 | Claim accepted this cycle |
| claimReject | output | 1 | Claim refused due to overlap this cycle |
| claimOut | output | NUM_IRQ | Current claim register |
| takeIrq | output | 1 | An interrupt should be taken |
| irqCause | output | CAUSE_W | Index of the selected interrupt |

## Verification
The assertions assume that privLvl never carries the reserved encoding 2. The stimulus only ever drives 0, 1 or 3. They also assume that NUM_IRQ is a power of two, so that irqCause always indexes a real bit. The bench instance uses 8 lines.

The sweep sets every 8-bit pending value through the update port with a full mask. For each value it crosses several enable and delegation patterns with all legal privilege levels and both global enables. A bench-side arithmetic model predicts the cause. Partial-mask updates use bench-generated pseudo-random masks and values, and each one is followed by a cycle with updValid low to show that the register holds.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } privLvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pendWrite;
    logic claimWrite;
    logic claimReject;
    logic machGate;
    logic supGate;
  } dpStrobe_t;

endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int NUM_IRQ = 32,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] reqVec,
  output logic               anyReq,
  output logic [CAUSE_W-1:0] pickIdx
);

  logic [NUM_IRQ:0]   seenBelow;
  logic [NUM_IRQ-1:0] grantVec;

  assign seenBelow[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : gChain
      assign grantVec[g]    = reqVec[g] & ~seenBelow[g];
      assign seenBelow[g+1] = seenBelow[g] | reqVec[g];
    end
  endgenerate

  assign anyReq = seenBelow[NUM_IRQ];

  always_comb begin
    pickIdx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grantVec[i]) pickIdx = pickIdx | CAUSE_W'(i);
    end
  end

endmodule

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] privLvl,
  input  logic      mIntEn,
  input  logic      sIntEn,
  input  logic      updValid,
  input  logic      claimValid,
  input  logic      claimOverlap,
  output dpStrobe_t strb
);

  privLvl_e curPriv;
  assign curPriv = privLvl_e'(privLvl);

  always_comb begin
    strb = '0;
    strb.pendWrite   = updValid;
    strb.claimWrite  = claimValid & ~claimOverlap;
    strb.claimReject = claimValid &  claimOverlap;
    // machine-handled lines: anything below M, or M with its enable
    strb.machGate = (curPriv != PRIV_M) | mIntEn;
    // supervisor-handled lines: U always, S with its enable, never M
    unique case (curPriv)
      PRIV_U:  strb.supGate = 1'b1;
      PRIV_S:  strb.supGate = sIntEn;
      default: strb.supGate = 1'b0;
    endcase
  end

  // R3 input assumption: reserved privilege encoding never applied
  priv_legal_chk: assert property (@(posedge clk) disable iff (rst)
    privLvl != 2'd2);

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strb,
  input  logic [NUM_IRQ-1:0] enableMask,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  logic [NUM_IRQ-1:0] updMask,
  input  logic [NUM_IRQ-1:0] updValue,
  input  logic [NUM_IRQ-1:0] claimBits,
  output logic [NUM_IRQ-1:0] pendingQ,
  output logic [NUM_IRQ-1:0] claimQ,
  output logic               claimOverlap,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] irqCause
);

  logic [NUM_IRQ-1:0] pendingD;
  logic [NUM_IRQ-1:0] claimD;
  logic [NUM_IRQ-1:0] candVec;
  logic [NUM_IRQ-1:0] gateVec;
  logic [NUM_IRQ-1:0] eligVec;
  logic [NUM_IRQ-1:0] lowMask;

  // pending register with masked merge
  always_comb begin
    pendingD = pendingQ;
    if (strb.pendWrite) pendingD = (pendingQ & ~updMask) | (updValue & updMask);
  end

  always_ff @(posedge clk) begin
    if (rst) pendingQ <= '0;
    else     pendingQ <= pendingD;
  end

  // claim register, grows only
  assign claimOverlap = |(claimQ & claimBits);

  always_comb begin
    claimD = claimQ;
    if (strb.claimWrite) claimD = claimQ | claimBits;
  end

  always_ff @(posedge clk) begin
    if (rst) claimQ <= '0;
    else     claimQ <= claimD;
  end

  // eligibility per line
  assign candVec = pendingQ & enableMask;
  assign gateVec = (~delegMask & {NUM_IRQ{strb.machGate}})
                 | ( delegMask & {NUM_IRQ{strb.supGate}});
  assign eligVec = candVec & gateVec;

  irq_lsb_pick #(.NUM_IRQ(NUM_IRQ)) uPick (
    .reqVec (eligVec),
    .anyReq (takeIrq),
    .pickIdx(irqCause)
  );

  assign lowMask = ~({NUM_IRQ{1'b1}} << irqCause);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pendingQ == '0 && claimQ == '0));

  // R7
  pend_merge_chk: assert property (@(posedge clk) disable iff (rst)
    strb.pendWrite |=> pendingQ ==
      (($past(pendingQ) & ~$past(updMask)) | ($past(updValue) & $past(updMask))));

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.pendWrite |=> $stable(pendingQ));

  // R9
  claim_reject_chk: assert property (@(posedge clk) disable iff (rst)
    strb.claimReject |=> $stable(claimQ));

  // R10
  claim_grow_chk: assert property (@(posedge clk) disable iff (rst)
    strb.claimWrite |=> claimQ == ($past(claimQ) | $past(claimBits)));

  // R5
  lowest_win_chk: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> (pendingQ[irqCause] && enableMask[irqCause] &&
                 (eligVec & lowMask) == '0));

  // R2
  cand_only_chk: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> candVec[irqCause]);

  // R6
  idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !takeIrq |-> (irqCause == '0 && eligVec == '0));

endmodule

// File: rtl/irq_selector.sv
module irq_selector
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         privLvl,
  input  logic               mIntEn,
  input  logic               sIntEn,
  input  logic [NUM_IRQ-1:0] enableMask,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  logic               updValid,
  input  logic [NUM_IRQ-1:0] updMask,
  input  logic [NUM_IRQ-1:0] updValue,
  output logic [NUM_IRQ-1:0] pendingOld,
  input  logic               claimValid,
  input  logic [NUM_IRQ-1:0] claimBits,
  output logic               claimGrant,
  output logic               claimReject,
  output logic [NUM_IRQ-1:0] claimOut,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] irqCause
);

  dpStrobe_t          strb;
  logic               claimOverlap;
  logic [NUM_IRQ-1:0] pendingQ;
  logic [NUM_IRQ-1:0] claimQ;

  irq_sel_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .privLvl     (privLvl),
    .mIntEn      (mIntEn),
    .sIntEn      (sIntEn),
    .updValid    (updValid),
    .claimValid  (claimValid),
    .claimOverlap(claimOverlap),
    .strb        (strb)
  );

  irq_sel_dp #(.NUM_IRQ(NUM_IRQ)) uDp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .enableMask  (enableMask),
    .delegMask   (delegMask),
    .updMask     (updMask),
    .updValue    (updValue),
    .claimBits   (claimBits),
    .pendingQ    (pendingQ),
    .claimQ      (claimQ),
    .claimOverlap(claimOverlap),
    .takeIrq     (takeIrq),
    .irqCause    (irqCause)
  );

  assign pendingOld  = pendingQ;
  assign claimOut    = claimQ;
  assign claimGrant  = strb.claimWrite;
  assign claimReject = strb.claimReject;

  // R4
  mmode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (takeIrq && privLvl == 2'd3) |-> (mIntEn && !delegMask[irqCause]));

  // R3
  smode_mach_chk: assert property (@(posedge clk) disable iff (rst)
    (takeIrq && privLvl == 2'd1 && !sIntEn) |-> !delegMask[irqCause]);

endmodule

// File: tb/tb_irq_selector.sv
module tb_irq_selector;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    privLvl;
  logic          mIntEn, sIntEn;
  logic [N-1:0]  enableMask, delegMask;
  logic          updValid;
  logic [N-1:0]  updMask, updValue;
  logic [N-1:0]  pendingOld;
  logic          claimValid;
  logic [N-1:0]  claimBits;
  logic          claimGrant, claimReject;
  logic [N-1:0]  claimOut;
  logic          takeIrq;
  logic [CW-1:0] irqCause;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] modelPend = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_selector #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst(rst), .privLvl(privLvl), .mIntEn(mIntEn), .sIntEn(sIntEn),
    .enableMask(enableMask), .delegMask(delegMask), .updValid(updValid),
    .updMask(updMask), .updValue(updValue), .pendingOld(pendingOld),
    .claimValid(claimValid), .claimBits(claimBits), .claimGrant(claimGrant),
    .claimReject(claimReject), .claimOut(claimOut), .takeIrq(takeIrq),
    .irqCause(irqCause)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic model of the selection
  task automatic expectSel(input string tag);
    logic [N-1:0] elig;
    logic mOk, sOk;
    logic expTake;
    logic [CW-1:0] expCause;
    mOk = (privLvl != 2'd3) || mIntEn;
    sOk = (privLvl == 2'd0) || (privLvl == 2'd1 && sIntEn);
    elig = '0;
    for (int b = 0; b < N; b++)
      if (modelPend[b] && enableMask[b] && (delegMask[b] ? sOk : mOk)) elig[b] = 1'b1;
    expTake = 1'b0;
    expCause = '0;
    for (int b = N - 1; b >= 0; b--)
      if (elig[b]) begin expTake = 1'b1; expCause = CW'(b); end
    check(tag, {31'd0, takeIrq}, {31'd0, expTake});
    check(tag, {29'd0, irqCause}, {29'd0, expCause});
  endtask

  task automatic doUpdate(input logic [N-1:0] m, input logic [N-1:0] v);
    @(negedge clk);
    updValid = 1'b1; updMask = m; updValue = v;
    #1 check("R7 old value", {24'd0, pendingOld}, {24'd0, modelPend});
    @(negedge clk);
    updValid = 1'b0;
    modelPend = (modelPend & ~m) | (v & m);
    #1 check("R7 merge", {24'd0, pendingOld}, {24'd0, modelPend});
  endtask

  function automatic logic [N-1:0] enPat(input int k);
    case (k)
      0: return 8'hFF;
      1: return 8'hA5;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [N-1:0] dgPat(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h3C;
      default: return 8'hC3;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; privLvl = 2'd0; mIntEn = 1'b0; sIntEn = 1'b0;
    enableMask = '0; delegMask = '0; updValid = 1'b0; updMask = '0;
    updValue = '0; claimValid = 1'b0; claimBits = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1 pending", {24'd0, pendingOld}, 32'd0);
    check("R1 claim", {24'd0, claimOut}, 32'd0);
    check("R1 take", {31'd0, takeIrq}, 32'd0);

    // targeted cases
    doUpdate(8'hFF, 8'h01);
    enableMask = 8'h00; privLvl = 2'd0; #1;
    check("R2 disabled line", {31'd0, takeIrq}, 32'd0);
    enableMask = 8'h01; #1;
    check("R11 same-cycle take", {31'd0, takeIrq}, 32'd1);
    privLvl = 2'd3; mIntEn = 1'b0; delegMask = 8'h00; #1;
    check("R3 M without enable", {31'd0, takeIrq}, 32'd0);
    mIntEn = 1'b1; #1;
    check("R3 M with enable", {31'd0, takeIrq}, 32'd1);
    delegMask = 8'h01; sIntEn = 1'b1; #1;
    check("R4 delegated in M", {31'd0, takeIrq}, 32'd0);
    privLvl = 2'd1; sIntEn = 1'b0; #1;
    check("R4 S without enable", {31'd0, takeIrq}, 32'd0);
    sIntEn = 1'b1; #1;
    check("R4 S with enable", {31'd0, takeIrq}, 32'd1);

    // R8: updValid low with busy mask/value
    @(negedge clk);
    updMask = 8'hFF; updValue = 8'h5A;
    @(negedge clk); #1;
    check("R8 hold", {24'd0, pendingOld}, {24'd0, modelPend});

    // partial-mask updates
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] m, v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr[7:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr[15:8];
      doUpdate(m, v);
      @(negedge clk);
      updMask = ~m; updValue = ~v;
      @(negedge clk); #1;
      check("R8 hold after merge", {24'd0, pendingOld}, {24'd0, modelPend});
    end

    // exhaustive sweep of pending values
    for (int p = 0; p < 256; p++) begin
      doUpdate(8'hFF, N'(p));
      for (int e = 0; e < 3; e++)
        for (int d = 0; d < 4; d++)
          for (int pr = 0; pr < 3; pr++)
            for (int me = 0; me < 2; me++)
              for (int se = 0; se < 2; se++) begin
                enableMask = enPat(e);
                delegMask = dgPat(d);
                privLvl = (pr == 2) ? 2'd3 : 2'(pr);
                mIntEn = me[0];
                sIntEn = se[0];
                #1 expectSel("R5 R6 sweep");
              end
    end

    // claim register
    @(negedge clk);
    claimValid = 1'b1; claimBits = 8'h03; #1;
    check("R10 grant", {31'd0, claimGrant}, 32'd1);
    @(negedge clk);
    claimBits = 8'h06; #1;
    check("R10 stored", {24'd0, claimOut}, 32'h03);
    check("R9 reject", {31'd0, claimReject}, 32'd1);
    check("R9 no grant", {31'd0, claimGrant}, 32'd0);
    @(negedge clk);
    claimBits = 8'h0C; #1;
    check("R9 unchanged", {24'd0, claimOut}, 32'h03);
    check("R10 grant disjoint", {31'd0, claimGrant}, 32'd1);
    @(negedge clk);
    claimValid = 1'b0; #1;
    check("R10 accumulate", {24'd0, claimOut}, 32'h0F);
    check("R9 idle no reject", {31'd0, claimReject}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule